// File: doc/BRIEF.md
# Sequential Restoring Divider with Sticky Overflow Flag

This block divides an unsigned double-width dividend by a single-width divisor and returns a single-width quotient and remainder. It uses shift-and-subtract restoring division and retires one quotient bit per clock. The high half of the dividend sits in a partial-remainder register that is one bit wider than the divisor, so the sign of each trial subtraction is visible. The low half sits in the quotient register.

A one-cycle `start` pulse loads the operands. In that same cycle the block checks whether the upper half of the dividend is at least the divisor. This test also catches a zero divisor. If the check fails, the block raises a sticky overflow flag and reports completion at once, without dividing. Otherwise it runs exactly `N` iterations and then pulses `done`. The results and the flag hold until the next accepted `start`.

Top module: `seqdiv_restore`

## Requirements
- R1: After reset, `done`, `ovf_flag`, `quotient` and `remainder` are all 0.
- R2: When `dividend[2N-1:N] < divisor`, the block completes with `quotient` equal to floor(dividend / divisor) and `remainder` equal to dividend mod divisor, and with `ovf_flag` at 0.
- R3: When `dividend[2N-1:N] >= divisor`, the block sets `ovf_flag` to 1. It raises `done` in the cycle right after the cycle that sampled `start`. `quotient` then equals `dividend[N-1:0]` and `remainder` equals `dividend[2N-1:N]`.
- R4: A divisor of 0 always takes the overflow path of R3, for any dividend.
- R5: For a division without overflow, `done` rises N+1 cycles after the cycle that sampled `start`. With the default N = 8 that is 9 cycles.
- R6: `done` is high for exactly one cycle per accepted `start`.
- R7: `ovf_flag` keeps its value after completion until the next accepted `start`. That start replaces it with the new overflow result.
- R8: A `start` that arrives while a division is running is ignored. The running division completes with its original operands and its original timing.
- R9: `quotient` and `remainder` hold their final values after `done` until the next accepted `start`.
- R10: The largest non-overflowing high half (`dividend[2N-1:N] = divisor - 1`) divides correctly. A high half equal to the divisor overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| start | input | 1 | One-cycle request to load operands; honoured only when idle |
| dividend | input | 2N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | N | Quotient, or low dividend half on overflow |
| remainder | output | N | Remainder, or high dividend half on overflow |
| ovf_flag | output | 1 | Sticky divide-overflow indicator |

## Verification
The assertions check the following on every cycle:
- the completion pulse lasts one cycle;
- the iteration counter counts down one step per cycle while busy;
- the overflow flag moves only when an operand load happens;
- an overflowing load finishes on the next cycle with the flag set;
- the result registers stay frozen while idle;
- every non-overflowing result leaves a remainder below the divisor.

Only the bench scenarios can show the rest:
- that the quotient and remainder are the true arithmetic results;
- the exact latency of a full division;
- that a start arriving mid-division is dropped without disturbing the result;
- the boundary between a high half of divisor - 1 and one equal to the divisor.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
  typedef enum logic [0:0] {
    DV_IDLE = 1'b0,
    DV_RUN  = 1'b1
  } dv_state_t;
endpackage

// File: rtl/seqdiv_step.sv
module seqdiv_step #(
  parameter int N = 8
) (
  input  logic [N:0]   part_in,
  input  logic [N-1:0] quo_in,
  input  logic [N-1:0] dvs_in,
  output logic [N:0]   part_out,
  output logic [N-1:0] quo_out
);
  logic [N:0] shifted;
  logic [N:0] trial;

  always_comb begin
    shifted = {part_in[N-1:0], quo_in[N-1]};
    trial   = shifted - {1'b0, dvs_in};
    if (trial[N]) begin
      part_out = shifted;
      quo_out  = {quo_in[N-2:0], 1'b0};
    end else begin
      part_out = trial;
      quo_out  = {quo_in[N-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/seqdiv_ctrl.sv
module seqdiv_ctrl
  import seqdiv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ovf_hit,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] ITER = CW'(N);
  localparam logic [CW-1:0] ONE  = CW'(1);

  dv_state_t     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;
  logic          cnt_en;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      DV_IDLE: begin
        if (start) begin
          load = 1'b1;
          if (ovf_hit) begin
            done_n = 1'b1;
          end else begin
            state_n = DV_RUN;
            cnt_n   = ITER;
            cnt_en  = 1'b1;
          end
        end
      end
      DV_RUN: begin
        step   = 1'b1;
        cnt_en = 1'b1;
        cnt_n  = cnt_q - ONE;
        if (cnt_q == ONE) begin
          state_n = DV_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = DV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign busy = (state_q == DV_RUN);
  assign done = done_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != ONE) |=> (busy && cnt_q == $past(cnt_q) - ONE));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);
endmodule

// File: rtl/seqdiv_restore.sv
module seqdiv_restore #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic           done,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder,
  output logic           ovf_flag
);
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [N:0]   part_q, part_d;
  logic [N-1:0] quo_q, quo_d;
  logic [N-1:0] dvs_q;
  logic         ovf_q;
  logic         load, step, busy;
  logic         ovf_hit;
  logic [N:0]   part_nx;
  logic [N-1:0] quo_nx;

  assign ovf_hit = (dividend[2*N-1:N] >= divisor);

  seqdiv_ctrl #(.N(N)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_s),
    .start   (start),
    .ovf_hit (ovf_hit),
    .load    (load),
    .step    (step),
    .busy    (busy),
    .done    (done)
  );

  seqdiv_step #(.N(N)) step_i (
    .part_in  (part_q),
    .quo_in   (quo_q),
    .dvs_in   (dvs_q),
    .part_out (part_nx),
    .quo_out  (quo_nx)
  );

  always_comb begin
    part_d = part_q;
    quo_d  = quo_q;
    if (load) begin
      part_d = {1'b0, dividend[2*N-1:N]};
      quo_d  = dividend[N-1:0];
    end else if (step) begin
      part_d = part_nx;
      quo_d  = quo_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      part_q <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (load || step) begin
        part_q <= part_d;
        quo_q  <= quo_d;
      end
      if (load) begin
        dvs_q <= divisor;
        ovf_q <= ovf_hit;
      end
    end
  end

  assign quotient  = quo_q;
  assign remainder = part_q[N-1:0];
  assign ovf_flag  = ovf_q;

  p_ovf_fast_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (load && ovf_hit) |=> (done && ovf_flag && !busy));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !load |=> $stable(ovf_flag));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (!load && !step) |=> ($stable(quotient) && $stable(remainder)));

  p_rem_below_div_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (done && !ovf_flag) |-> (part_q < {1'b0, dvs_q}));
endmodule

// File: tb/seqdiv_restore_tb_top.sv
module seqdiv_restore_tb_top;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic         done;
  logic [N-1:0] quotient, remainder;
  logic         ovf_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  seqdiv_restore #(.N(N)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .ovf_flag  (ovf_flag)
  );

  localparam logic [W+N-1:0] VEC [8] = '{
    {16'h0000, 8'h01}, {16'h00FF, 8'h01}, {16'h1234, 8'h56},
    {16'hFEFF, 8'hFF}, {16'h7FFF, 8'h80}, {16'h0A0B, 8'h0C},
    {16'h1200, 8'h12}, {16'h0345, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_div(input logic [W-1:0] dvd, input logic [N-1:0] dvs,
                         input bit poke_mid);
    int lat;
    bit exp_ovf;
    int exp_q, exp_r, exp_lat;
    logic [W-1:0] d_full;
    logic [N-1:0] d_hi;
    d_full  = dvd;
    d_hi    = dvd[W-1:N];
    exp_ovf = (d_hi >= dvs);
    if (exp_ovf) begin
      exp_q = int'(dvd[N-1:0]);
      exp_r = int'(d_hi);
      exp_lat = 1;
    end else begin
      exp_q = int'(d_full / W'(dvs));
      exp_r = int'(d_full % W'(dvs));
      exp_lat = N + 1;
    end
    @(negedge clk);
    start = 1'b1; dividend = dvd; divisor = dvs;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (!exp_ovf) chk(ovf_flag == 1'b0, "R7 flag replaced at start", int'(ovf_flag), 0);
    while (!done && lat < 40) begin
      if (poke_mid && lat == 3) begin
        start = 1'b1; dividend = 16'h0101; divisor = 8'h00;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (exp_ovf) begin
      chk(lat == exp_lat, "R3 overflow latency", lat, exp_lat);
      chk(ovf_flag == 1'b1, "R3/R4 overflow flag", int'(ovf_flag), 1);
      chk(int'(quotient) == exp_q, "R3 quotient keeps low half", int'(quotient), exp_q);
      chk(int'(remainder) == exp_r, "R3 remainder keeps high half", int'(remainder), exp_r);
    end else begin
      chk(lat == exp_lat, poke_mid ? "R8 latency with ignored start" : "R5 latency", lat, exp_lat);
      chk(ovf_flag == 1'b0, "R2 no overflow", int'(ovf_flag), 0);
      chk(int'(quotient) == exp_q, poke_mid ? "R8 quotient" : "R2 quotient", int'(quotient), exp_q);
      chk(int'(remainder) == exp_r, poke_mid ? "R8 remainder" : "R2 remainder", int'(remainder), exp_r);
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'(quotient) == exp_q, "R9 quotient held", int'(quotient), exp_q);
    chk(int'(remainder) == exp_r, "R9 remainder held", int'(remainder), exp_r);
    chk(ovf_flag == exp_ovf, "R7 flag sticky", int'(ovf_flag), int'(exp_ovf));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(ovf_flag == 1'b0, "R1 reset flag", int'(ovf_flag), 0);
    chk(quotient == '0, "R1 reset quotient", int'(quotient), 0);
    chk(remainder == '0, "R1 reset remainder", int'(remainder), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R1 idle after release", int'(done), 0);

    for (int i = 0; i < 8; i++) begin
      run_div(VEC[i][W+N-1:N], VEC[i][N-1:0], 1'b0);
    end

    // R10 boundary: high half one below divisor, then equal to it
    run_div(16'h34FF, 8'h35, 1'b0);
    run_div(16'h35FF, 8'h35, 1'b0);
    // R4 zero divisor with an all-zero dividend
    run_div(16'h0000, 8'h00, 1'b0);
    // R7 sticky flag then cleared by a normal start
    run_div(16'hFFFF, 8'h10, 1'b0);
    run_div(16'h0F00, 8'h10, 1'b0);
    // R8 start during a running division is dropped
    run_div(16'h3A7C, 8'hC3, 1'b1);
    run_div(16'h0001, 8'hFF, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule